// File: doc/BRIEF.md
# Two-Cycle Packed-BCD Adder/Subtractor

This unit adds or subtracts two operands together with an incoming carry. The operands are binary words or packed decimal numbers, one decimal digit per nibble. A single start strobe launches each operation. The unit then reports the result together with carry, zero, negative and overflow flags, and raises a one-clock done pulse when they are valid.

In binary mode the operation completes in the clock that samples the start strobe. In decimal mode the work is split into two clocks:

- The first clock performs the plain binary operation and registers the intermediate value and the per-digit carries.
- The second clock applies only the decimal digit correction to that registered value.

This keeps the binary carry chain and the correction logic in separate register stages. The operand width is set by the number of digits.

Top module: `bcd_addsub_unit`

## Requirements
- R1: With `dec_mode`=0 and `sub_sel`=0, an accepted start yields `result` = (A + B + `carry_in`) mod 2^W and `carry_out` = bit W of that sum. `done` is high in the cycle right after the accepting clock edge.
- R2: With `dec_mode`=0 and `sub_sel`=1, `result` = (A + ~B + `carry_in`) mod 2^W. `carry_out` is 1 when no borrow occurred, so `carry_in`=1 means no borrow in. `done` has the same timing as R1.
- R3: With `dec_mode`=1, `done` stays low in the cycle after the accepting edge and rises in the cycle after that. A decimal operation therefore takes exactly one clock more than a binary one.
- R4: Decimal add of valid BCD operands gives the decimal sum A + B + `carry_in`, modulo 10^D (D = number of digits). `carry_out` is 1 when the decimal sum reached 10^D. A correction in one digit may ripple into the next digit.
- R5: Decimal subtract of valid BCD operands gives A − B − (1 − `carry_in`), modulo 10^D. `carry_out` is 1 when that value is not negative.
- R6: `ovf_flag` is the two's-complement overflow of the binary operation (A + B or A + ~B, plus `carry_in`), in both modes.
- R7: `zero_flag` is 1 exactly when the final `result` is all zeros. `neg_flag` equals the top bit of the final `result`.
- R8: `done` is a one-clock pulse per accepted operation. `result` and all flags hold their values while no operation completes.
- R9: A start that arrives while a decimal second cycle is pending is ignored. The pending decimal result is delivered and no extra `done` pulse follows.
- R10: While `rst_n` is low, `result`, all flags and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch an operation with the operands present this cycle |
| op_a | input | 4*DIGITS | First operand |
| op_b | input | 4*DIGITS | Second operand |
| carry_in | input | 1 | Incoming carry (1 = no borrow when subtracting) |
| sub_sel | input | 1 | 0 = add, 1 = subtract |
| dec_mode | input | 1 | 0 = binary, 1 = packed decimal |
| result | output | 4*DIGITS | Final result |
| carry_out | output | 1 | Carry out (1 = no borrow when subtracting) |
| zero_flag | output | 1 | Result is zero |
| neg_flag | output | 1 | Top bit of result |
| ovf_flag | output | 1 | Signed overflow of the binary operation |
| done | output | 1 | Result and flags valid, one-clock pulse |

## Verification
The bench builds the unit twice: once with the default of two digits and once with three digits.

The two-digit instance walks a vector table covering both modes and both directions. It also runs the timing and start-ignore cases.

The three-digit instance provides a middle digit. That is where a correction in the lowest digit must ripple through a second corrected digit into the top one. It is also where a subtract borrow propagates across several digits at once. A two-digit build cannot show either case.

// File: rtl/bcd_au_pkg.sv
package bcd_au_pkg;
   localparam int NIB = 4;

   typedef struct packed {
      logic c;
      logic z;
      logic n;
      logic v;
   } au_flags_t;

   function automatic logic [4:0] nib_plus6(input logic [4:0] x);
      return x + 5'd6;
   endfunction
endpackage

// File: rtl/bcd_bin_stage.sv
module bcd_bin_stage
   import bcd_au_pkg::*;
#(
   parameter int DIGITS = 2,
   localparam int W = DIGITS * NIB
) (
   input  logic [W-1:0]      a,
   input  logic [W-1:0]      b,
   input  logic              cin,
   input  logic              sub,
   output logic [W-1:0]      sum,
   output logic [DIGITS-1:0] dcar,
   output logic              ovf
);
   logic [W-1:0]  bx;
   logic [DIGITS:0] chain;

   assign bx       = sub ? ~b : b;
   assign chain[0] = cin;

   for (genvar i = 0; i < DIGITS; i++) begin : g_dig
      logic [NIB:0] t;
      assign t            = {1'b0, a[i*NIB +: NIB]} + {1'b0, bx[i*NIB +: NIB]} + {{NIB{1'b0}}, chain[i]};
      assign sum[i*NIB +: NIB] = t[NIB-1:0];
      assign chain[i+1]   = t[NIB];
      assign dcar[i]      = t[NIB];
   end

   assign ovf = (a[W-1] ~^ bx[W-1]) & (a[W-1] ^ sum[W-1]);
endmodule

// File: rtl/bcd_fix_stage.sv
module bcd_fix_stage
   import bcd_au_pkg::*;
#(
   parameter int DIGITS = 2,
   localparam int W = DIGITS * NIB
) (
   input  logic [W-1:0]      raw,
   input  logic [DIGITS-1:0] dcar,
   input  logic              sub,
   output logic [W-1:0]      fixed,
   output logic              dec_c
);
   logic [DIGITS:0]   k;
   logic [DIGITS-1:0] fixv;

   assign k[0] = 1'b0;

   for (genvar i = 0; i < DIGITS; i++) begin : g_dig
      logic [NIB-1:0] d;
      logic [NIB:0]   t;
      logic [NIB:0]   adj;
      logic [NIB-1:0] out_add;
      logic [NIB-1:0] out_sub;

      assign d       = raw[i*NIB +: NIB];
      // the carry produced by the correction of the digit below enters here
      assign t       = {1'b0, d} + {{NIB{1'b0}}, k[i]};
      assign fixv[i] = (t > 5'd9) | dcar[i];
      assign adj     = fixv[i] ? nib_plus6(t) : t;
      assign out_add = adj[NIB-1:0];
      assign k[i+1]  = adj[NIB];
      // a digit that borrowed holds 16 too many, so taking 6 away leaves it in range
      assign out_sub = dcar[i] ? d : d - 4'd6;
      assign fixed[i*NIB +: NIB] = sub ? out_sub : out_add;
   end

   assign dec_c = sub ? dcar[DIGITS-1] : fixv[DIGITS-1];
endmodule

// File: rtl/bcd_seq_ctrl.sv
module bcd_seq_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic dec_mode,
   output logic take_bin,
   output logic take_dec,
   output logic finish,
   output logic pend,
   output logic done
);
   logic accept;

   assign accept   = start & ~pend;
   assign take_bin = accept & ~dec_mode;
   assign take_dec = accept & dec_mode;
   assign finish   = pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         done <= 1'b0;
      end else begin
         pend <= take_dec;
         done <= take_bin | finish;
      end
   end
endmodule

// File: rtl/bcd_addsub_unit.sv
module bcd_addsub_unit
   import bcd_au_pkg::*;
#(
   parameter int DIGITS = 2,
   localparam int W = DIGITS * NIB
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   input  logic         carry_in,
   input  logic         sub_sel,
   input  logic         dec_mode,
   output logic [W-1:0] result,
   output logic         carry_out,
   output logic         zero_flag,
   output logic         neg_flag,
   output logic         ovf_flag,
   output logic         done
);
   if (DIGITS < 1 || DIGITS > 16) begin : g_bad_digits
      $error("bcd_addsub_unit: DIGITS must lie in 1..16");
   end

   logic              take_bin, take_dec, finish, pend_w;
   logic [W-1:0]      bin_sum;
   logic [DIGITS-1:0] bin_dcar;
   logic              bin_ovf;

   logic [W-1:0]      mid_sum;
   logic [DIGITS-1:0] mid_dcar;
   logic              mid_ovf;
   logic              mid_sub;

   logic [W-1:0]      fix_val;
   logic              fix_c;

   logic [W-1:0]      res_q;
   au_flags_t         flg_q;

   bcd_seq_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .dec_mode (dec_mode),
      .take_bin (take_bin),
      .take_dec (take_dec),
      .finish   (finish),
      .pend     (pend_w),
      .done     (done)
   );

   bcd_bin_stage #(.DIGITS(DIGITS)) u_bin (
      .a    (op_a),
      .b    (op_b),
      .cin  (carry_in),
      .sub  (sub_sel),
      .sum  (bin_sum),
      .dcar (bin_dcar),
      .ovf  (bin_ovf)
   );

   bcd_fix_stage #(.DIGITS(DIGITS)) u_fix (
      .raw   (mid_sum),
      .dcar  (mid_dcar),
      .sub   (mid_sub),
      .fixed (fix_val),
      .dec_c (fix_c)
   );

   // intermediate stage: binary result held for the decimal correction clock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mid_sum  <= '0;
         mid_dcar <= '0;
         mid_ovf  <= 1'b0;
         mid_sub  <= 1'b0;
      end else if (take_dec) begin
         mid_sum  <= bin_sum;
         mid_dcar <= bin_dcar;
         mid_ovf  <= bin_ovf;
         mid_sub  <= sub_sel;
      end
   end

   // output stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q <= '0;
         flg_q <= '0;
      end else if (take_bin) begin
         res_q   <= bin_sum;
         flg_q.c <= bin_dcar[DIGITS-1];
         flg_q.z <= (bin_sum == '0);
         flg_q.n <= bin_sum[W-1];
         flg_q.v <= bin_ovf;
      end else if (finish) begin
         res_q   <= fix_val;
         flg_q.c <= fix_c;
         flg_q.z <= (fix_val == '0);
         flg_q.n <= fix_val[W-1];
         flg_q.v <= mid_ovf;
      end
   end

   assign result    = res_q;
   assign carry_out = flg_q.c;
   assign zero_flag = flg_q.z;
   assign neg_flag  = flg_q.n;
   assign ovf_flag  = flg_q.v;
endmodule

// File: rtl/bcd_addsub_chk.sv
module bcd_addsub_chk #(
   parameter int DIGITS = 2,
   localparam int W = DIGITS * 4
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         dec_mode,
   input logic         pend,
   input logic         done,
   input logic [W-1:0] result,
   input logic         zero_flag,
   input logic         neg_flag,
   input logic         carry_out,
   input logic         ovf_flag
);
   AST_BIN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !dec_mode && !pend) |=> done); // R1
   AST_DEC_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && dec_mode && !pend) |=> (!done ##1 done)); // R3
   AST_PEND_DELIVERS: assert property (@(posedge clk) disable iff (!rst_n)
      pend |=> done); // R3
   AST_NO_REPEND: assert property (@(posedge clk) disable iff (!rst_n)
      pend |=> !pend); // R9
   AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (zero_flag == (result == '0))); // R7
   AST_NEG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (neg_flag == result[W-1])); // R7
   AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(result) && $stable(carry_out) && $stable(ovf_flag))); // R8
endmodule

bind bcd_addsub_unit bcd_addsub_chk #(.DIGITS(DIGITS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .dec_mode  (dec_mode),
   .pend      (pend_w),
   .done      (done),
   .result    (result),
   .zero_flag (zero_flag),
   .neg_flag  (neg_flag),
   .carry_out (carry_out),
   .ovf_flag  (ovf_flag)
);

// File: tb/tb_bcd_addsub_unit.sv
`timescale 1ns/1ps
module tb_bcd_addsub_unit;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   // two-digit instance
   logic       start = 0, cin = 0, sub = 0, dec = 0;
   logic [7:0] a = 0, b = 0;
   logic [7:0] res;
   logic       co, zf, nf, vf, dn;

   bcd_addsub_unit #(.DIGITS(2)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_a(a), .op_b(b),
      .carry_in(cin), .sub_sel(sub), .dec_mode(dec),
      .result(res), .carry_out(co), .zero_flag(zf), .neg_flag(nf),
      .ovf_flag(vf), .done(dn)
   );

   // three-digit instance
   logic        start3 = 0, cin3 = 0, sub3 = 0, dec3 = 0;
   logic [11:0] a3 = 0, b3 = 0;
   logic [11:0] res3;
   logic        co3, zf3, nf3, vf3, dn3;

   bcd_addsub_unit #(.DIGITS(3)) dut_w3 (
      .clk(clk), .rst_n(rst_n), .start(start3), .op_a(a3), .op_b(b3),
      .carry_in(cin3), .sub_sel(sub3), .dec_mode(dec3),
      .result(res3), .carry_out(co3), .zero_flag(zf3), .neg_flag(nf3),
      .ovf_flag(vf3), .done(dn3)
   );

   int total = 0;
   int bad = 0;
   bit ended = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic finish_up;
      if (!ended) begin
         ended = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // fields: dec, sub, cin, a, b, expected result, expected carry
   localparam int NV = 15;
   localparam logic [27:0] VEC [NV] = '{
      {1'b0, 1'b0, 1'b0, 8'h12, 8'h34, 8'h46, 1'b0},
      {1'b0, 1'b0, 1'b0, 8'hFF, 8'h01, 8'h00, 1'b1},
      {1'b0, 1'b0, 1'b1, 8'h7F, 8'h00, 8'h80, 1'b0},
      {1'b0, 1'b1, 1'b1, 8'h50, 8'h20, 8'h30, 1'b1},
      {1'b0, 1'b1, 1'b1, 8'h00, 8'h01, 8'hFF, 1'b0},
      {1'b0, 1'b1, 1'b1, 8'h80, 8'h01, 8'h7F, 1'b1},
      {1'b1, 1'b0, 1'b0, 8'h58, 8'h46, 8'h04, 1'b1},
      {1'b1, 1'b0, 1'b1, 8'h99, 8'h00, 8'h00, 1'b1},
      {1'b1, 1'b0, 1'b0, 8'h15, 8'h27, 8'h42, 1'b0},
      {1'b1, 1'b0, 1'b0, 8'h09, 8'h01, 8'h10, 1'b0},
      {1'b1, 1'b0, 1'b0, 8'h50, 8'h50, 8'h00, 1'b1},
      {1'b1, 1'b1, 1'b1, 8'h50, 8'h25, 8'h25, 1'b1},
      {1'b1, 1'b1, 1'b1, 8'h00, 8'h01, 8'h99, 1'b0},
      {1'b1, 1'b1, 1'b0, 8'h42, 8'h42, 8'h99, 1'b0},
      {1'b1, 1'b1, 1'b1, 8'h73, 8'h28, 8'h45, 1'b1}
   };

   // signed overflow of the binary operation (R6 definition)
   function automatic logic exp_ovf(input logic [7:0] x, input logic [7:0] y,
                                    input logic s, input logic c);
      logic [7:0] yy;
      logic [8:0] t;
      yy = s ? ~y : y;
      t  = {1'b0, x} + {1'b0, yy} + {8'd0, c};
      return (x[7] == yy[7]) && (t[7] != x[7]);
   endfunction

   // entered and left at a falling edge
   task automatic run8(input logic d, input logic s, input logic c,
                       input logic [7:0] x, input logic [7:0] y,
                       input logic [7:0] er, input logic ec);
      string tag;
      tag = d ? (s ? "R5" : "R4") : (s ? "R2" : "R1");
      start = 1; dec = d; sub = s; cin = c; a = x; b = y;
      @(negedge clk);
      start = 0;
      if (d) begin
         chk("R3 done low in first decimal cycle", {31'd0, dn}, 32'd0);
         @(negedge clk);
      end
      chk({tag, " done"}, {31'd0, dn}, 32'd1);
      chk({tag, " result"}, {24'd0, res}, {24'd0, er});
      chk({tag, " carry"}, {31'd0, co}, {31'd0, ec});
      chk("R6 overflow", {31'd0, vf}, {31'd0, exp_ovf(x, y, s, c)});
      chk("R7 zero", {31'd0, zf}, {31'd0, (er == 8'h00)});
      chk("R7 negative", {31'd0, nf}, {31'd0, er[7]});
      @(negedge clk);
      chk("R8 done single pulse", {31'd0, dn}, 32'd0);
   endtask

   initial begin
      #(4 * 50000);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      // R10: outputs during reset
      chk("R10 result in reset", {24'd0, res}, 32'd0);
      chk("R10 flags in reset", {27'd0, co, zf, nf, vf, dn}, 32'd0);
      rst_n = 1;
      @(negedge clk);
      chk("R10 idle after reset", {31'd0, dn}, 32'd0);

      for (int i = 0; i < NV; i++) begin
         run8(VEC[i][27], VEC[i][26], VEC[i][25], VEC[i][24:17],
              VEC[i][16:9], VEC[i][8:1], VEC[i][0]);
      end

      // R9: a start during the pending decimal cycle is ignored
      start = 1; dec = 1; sub = 0; cin = 0; a = 8'h38; b = 8'h19;
      @(negedge clk);
      dec = 0; a = 8'h01; b = 8'h01;
      @(negedge clk);
      start = 0;
      chk("R9 pending result delivered", {24'd0, res}, 32'h57);
      chk("R9 done on pending cycle", {31'd0, dn}, 32'd1);
      @(negedge clk);
      chk("R9 ignored start gives no done", {31'd0, dn}, 32'd0);
      chk("R9 ignored start leaves result", {24'd0, res}, 32'h57);

      // R8: outputs hold while inputs move without a start
      a = 8'hAA; b = 8'h55; sub = 1; dec = 1; cin = 1;
      repeat (3) @(negedge clk);
      chk("R8 result held", {24'd0, res}, 32'h57);
      chk("R8 carry held", {31'd0, co}, 32'd0);

      // back-to-back binary operations: one done per operation
      run8(1'b0, 1'b0, 1'b0, 8'h01, 8'h02, 8'h03, 1'b0);
      run8(1'b0, 1'b1, 1'b0, 8'h05, 8'h05, 8'hFF, 1'b0);

      // three-digit build: correction ripples through the middle digit (R4)
      start3 = 1; dec3 = 1; sub3 = 0; cin3 = 0; a3 = 12'h999; b3 = 12'h001;
      @(negedge clk);
      start3 = 0;
      chk("R3 w3 done low first cycle", {31'd0, dn3}, 32'd0);
      @(negedge clk);
      chk("R4 w3 ripple result", {20'd0, res3}, 32'h000);
      chk("R4 w3 ripple carry", {31'd0, co3}, 32'd1);
      chk("R7 w3 zero", {31'd0, zf3}, 32'd1);

      // three-digit build: borrow across two digits (R5)
      start3 = 1; dec3 = 1; sub3 = 1; cin3 = 1; a3 = 12'h500; b3 = 12'h001;
      @(negedge clk);
      start3 = 0;
      @(negedge clk);
      chk("R5 w3 borrow result", {20'd0, res3}, 32'h499);
      chk("R5 w3 borrow carry", {31'd0, co3}, 32'd1);
      chk("R5 w3 done", {31'd0, dn3}, 32'd1);

      // three-digit build: decimal add of 258 + 743 + 1 = 1002
      start3 = 1; dec3 = 1; sub3 = 0; cin3 = 1; a3 = 12'h258; b3 = 12'h743;
      @(negedge clk);
      start3 = 0;
      @(negedge clk);
      chk("R4 w3 add result", {20'd0, res3}, 32'h002);
      chk("R4 w3 add carry", {31'd0, co3}, 32'd1);

      @(negedge clk);
      finish_up();
   end
endmodule